// File: doc/BRIEF.md
# Text-Mode Colour Attribute Pixel Generator

This block is the pixel stage of an 80-column character display. For every pixel the timing logic presents the 16-bit cell word of the current screen position, the font row bits for the current scanline and the pixel position inside the character. The block picks one font bit, looks up a foreground and a background colour in two fixed 16-entry palettes, and drives a 12-bit RGB value a fixed two clocks later. Index 0 in both palettes gives green text on black, so cells written with only a character code (upper byte zero) look the same as on a monochrome screen.

A cursor cell shows a blinking inverse image. The blink phase advances on frame pulses. During the visible phase the colours of the cell under the cursor are exchanged. The block also holds a clear engine. When started, it drives the cell memory write port for one clock per cell and writes a space with the default colours to every address. While the engine runs, processor writes are not passed to the memory.

Top module: `txt_attr_pixgen`

## Requirements
- R1: After reset, rgb_valid is 0, rgb is 0, clr_busy is 0 and mem_we is 0.
- R2: The pixel uses font_row bit FONT_W-1-pix_idx, so pix_idx 0 is the leftmost pixel and uses the most significant bit. A bit of 1 gives the foreground colour selected by cell_word[11:8]. A bit of 0 gives the background colour selected by cell_word[15:12]. cell_word[7:0] does not affect the colour.
- R3: The foreground palette maps index 0 to 12'h0F0 and index 8 to 12'h555. Every other index i maps to {R,G,B}, where each channel is L if its bit (i[2] red, i[1] green, i[0] blue) is set and 0 otherwise, with L = 4'hF for i ≥ 8 and 4'hA below. The background palette maps index 0 to 12'h000 and index 8 to 12'h222. The other indices follow the same rule with L = 4'h8 for i ≥ 8 and 4'h4 below.
- R4: rgb and rgb_valid appear exactly two clocks after the pix_valid cycle that carried the inputs.
- R5: The blink phase starts hidden after reset and toggles on every BLINK_FRAMES-th frame_tick pulse (32 by default).
- R6: Foreground and background are exchanged only when cur_en is 1, the blink phase is visible, and cell_col/cell_row equal cur_col/cur_row.
- R7: A clr_start pulse while idle makes clr_busy high for exactly COLS*ROWS clocks. In each of those clocks mem_we is 1, mem_addr counts up from 0 by one, and mem_wdata is 16'h0020 (space, colour indices 0).
- R8: While idle, a processor write (cpu_we, cpu_addr, cpu_wdata) appears on mem_we, mem_addr and mem_wdata in the same cycle. While busy, the processor write is dropped and the port carries the clear data.
- R9: A clr_start pulse while busy does not restart or extend the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock pulse per frame |
| pix_valid | input | 1 | Pixel inputs are valid this cycle |
| cell_word | input | 16 | Background index, foreground index, character code |
| font_row | input | FONT_W | Font bits for the current scanline |
| pix_idx | input | PXW | Pixel position inside the cell, 0 = leftmost |
| cell_col | input | CW | Column of the current cell |
| cell_row | input | RW | Row of the current cell |
| cur_en | input | 1 | Cursor enable |
| cur_col | input | CW | Cursor column |
| cur_row | input | RW | Cursor row |
| rgb_valid | output | 1 | rgb is valid |
| rgb | output | 12 | Pixel colour, 4 bits per channel |
| clr_start | input | 1 | Start the clear engine |
| cpu_we | input | 1 | Processor cell write strobe |
| cpu_addr | input | AW | Processor cell address |
| cpu_wdata | input | 16 | Processor cell data |
| clr_busy | output | 1 | Clear in progress |
| mem_we | output | 1 | Cell memory write enable |
| mem_addr | output | AW | Cell memory address |
| mem_wdata | output | 16 | Cell memory write data |

## Verification
The bench checks the palette ends and its index 8 exceptions. If the index 0 rule were lost, legacy cells would not show green on black. If the bit order were reversed, glyphs would appear mirrored. It counts frame pulses across the 31st, 32nd and 64th pulse, where an off-by-one counter would blink early or late. It checks that the swap hits only the cursor cell, so a missing column or row compare would invert a whole row or column. During a clear it injects a processor write and a second start. A leaky write mux would corrupt memory, and a restartable engine would run longer than one pass of the screen.

// File: rtl/txt_attr_pkg.sv
package txt_attr_pkg;
   typedef logic [11:0] rgb12_t;

   function automatic rgb12_t pal_lookup(input logic [3:0] idx, input logic is_fg);
      logic [3:0] lvl;
      rgb12_t     c;
      if (is_fg) lvl = idx[3] ? 4'hF : 4'hA;
      else       lvl = idx[3] ? 4'h8 : 4'h4;
      c = {idx[2] ? lvl : 4'h0, idx[1] ? lvl : 4'h0, idx[0] ? lvl : 4'h0};
      if (idx == 4'd0 && is_fg)  c = 12'h0F0;
      if (idx == 4'd8)           c = is_fg ? 12'h555 : 12'h222;
      return c;
   endfunction
endpackage

// File: rtl/txt_palette.sv
module txt_palette
   import txt_attr_pkg::*;
#(
   parameter bit IS_FG = 1'b1
)(
   input  logic [3:0] idx,
   output rgb12_t     color
);
   generate
      if (IS_FG) begin : g_fg
         assign color = pal_lookup(idx, 1'b1);
      end else begin : g_bg
         assign color = pal_lookup(idx, 1'b0);
      end
   endgenerate
endmodule

// File: rtl/txt_blink.sv
module txt_blink #(
   parameter int PERIOD = 32
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic visible
);
   localparam int CNTW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   generate
      if (PERIOD < 1) begin : g_bad
         $error("txt_blink: PERIOD must be at least 1");
      end
   endgenerate

   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         visible <= 1'b0;
      end else if (tick) begin
         if (cnt == CNTW'(PERIOD - 1)) begin
            cnt     <= '0;
            visible <= ~visible;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R5
   phase_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n) && !$stable(visible)) |-> $past(tick));
endmodule

// File: rtl/txt_clear_eng.sv
module txt_clear_eng #(
   parameter int N_CELLS = 3200,
   parameter int AW      = 12
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(N_CELLS - 1);

   generate
      if (N_CELLS < 1 || N_CELLS > (1 << AW)) begin : g_bad
         $error("txt_clear_eng: N_CELLS does not fit the address width");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         addr <= '0;
      end else if (busy) begin
         if (addr == LAST) begin
            busy <= 1'b0;
            addr <= '0;
         end else begin
            addr <= addr + 1'b1;
         end
      end else if (start) begin
         busy <= 1'b1;
         addr <= '0;
      end
   end

   // R7
   clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr != LAST) |=> (busy && addr == $past(addr) + 1'b1));
   // R7
   clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr == LAST) |=> !busy);
   // R9
   clr_norestart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && addr != LAST) |=> addr != '0);
endmodule

// File: rtl/txt_attr_pixgen.sv
module txt_attr_pixgen
   import txt_attr_pkg::*;
#(
   parameter int         COLS         = 80,
   parameter int         ROWS         = 40,
   parameter int         FONT_W       = 8,
   parameter int         BLINK_FRAMES = 32,
   parameter logic [3:0] DEF_FG       = 4'd0,
   parameter logic [3:0] DEF_BG       = 4'd0,
   parameter logic [7:0] CLR_CHAR     = 8'h20,
   localparam int        N_CELLS      = COLS * ROWS,
   localparam int        AW           = $clog2(N_CELLS),
   localparam int        CW           = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int        RW           = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int        PXW          = (FONT_W > 1) ? $clog2(FONT_W) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              pix_valid,
   input  logic [15:0]       cell_word,
   input  logic [FONT_W-1:0] font_row,
   input  logic [PXW-1:0]    pix_idx,
   input  logic [CW-1:0]     cell_col,
   input  logic [RW-1:0]     cell_row,
   input  logic              cur_en,
   input  logic [CW-1:0]     cur_col,
   input  logic [RW-1:0]     cur_row,
   output logic              rgb_valid,
   output logic [11:0]       rgb,
   input  logic              clr_start,
   input  logic              cpu_we,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [15:0]       cpu_wdata,
   output logic              clr_busy,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [15:0]       mem_wdata
);
   localparam logic [15:0] DEF_CELL = {DEF_BG, DEF_FG, CLR_CHAR};

   generate
      if (COLS < 1 || ROWS < 1 || FONT_W < 1) begin : g_bad
         $error("txt_attr_pixgen: geometry parameters must be positive");
      end
   endgenerate

   // colour lookup
   rgb12_t fg_c, bg_c;
   txt_palette #(.IS_FG(1'b1)) u_pal_fg (.idx(cell_word[11:8]),  .color(fg_c));
   txt_palette #(.IS_FG(1'b0)) u_pal_bg (.idx(cell_word[15:12]), .color(bg_c));

   // blink phase
   logic blink_vis;
   txt_blink #(.PERIOD(BLINK_FRAMES)) u_blink (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .visible(blink_vis));

   // stage 1: colours, selected font bit, swap decision
   rgb12_t s1_fg, s1_bg;
   logic   s1_bit, s1_swap, s1_v;
   logic   at_cursor;

   assign at_cursor = cur_en && blink_vis && (cell_col == cur_col) && (cell_row == cur_row);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_fg   <= '0;
         s1_bg   <= '0;
         s1_bit  <= 1'b0;
         s1_swap <= 1'b0;
      end else begin
         s1_v    <= pix_valid;
         s1_fg   <= fg_c;
         s1_bg   <= bg_c;
         s1_bit  <= font_row[PXW'(FONT_W - 1) - pix_idx];
         s1_swap <= at_cursor;
      end
   end

   // stage 2: final colour
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rgb_valid <= 1'b0;
         rgb       <= '0;
      end else begin
         rgb_valid <= s1_v;
         rgb       <= (s1_bit ^ s1_swap) ? s1_fg : s1_bg;
      end
   end

   // clear engine and write port
   logic [AW-1:0] clr_addr;
   txt_clear_eng #(.N_CELLS(N_CELLS), .AW(AW)) u_clr (
      .clk(clk), .rst_n(rst_n), .start(clr_start), .busy(clr_busy), .addr(clr_addr));

   assign mem_we    = clr_busy | cpu_we;
   assign mem_addr  = clr_busy ? clr_addr : cpu_addr;
   assign mem_wdata = clr_busy ? DEF_CELL : cpu_wdata;

   // R4
   pix_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ##2 rgb_valid);
   // R8
   cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy && cpu_we) |-> (mem_wdata == DEF_CELL && mem_addr == clr_addr));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!rgb_valid && !clr_busy));
endmodule

// File: tb/txt_attr_pixgen_tb.sv
`timescale 1ns/1ps
module txt_attr_pixgen_tb;
   localparam int NC = 3200;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, frame_tick, pix_valid, cur_en, rgb_valid, clr_start, cpu_we;
   logic clr_busy, mem_we;
   logic [15:0] cell_word, cpu_wdata, mem_wdata;
   logic [7:0]  font_row;
   logic [2:0]  pix_idx;
   logic [6:0]  cell_col, cur_col;
   logic [5:0]  cell_row, cur_row;
   logic [11:0] rgb;
   logic [11:0] cpu_addr, mem_addr;

   txt_attr_pixgen u_dut (.*);

   int errors = 0, checks = 0;
   bit bvis = 0;
   int tcount = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] m_fg(input int i);
      int l;
      if (i == 0) return 12'h0F0;
      if (i == 8) return 12'h555;
      l = (i >= 8) ? 15 : 10;
      return {4'((i & 4) ? l : 0), 4'((i & 2) ? l : 0), 4'((i & 1) ? l : 0)};
   endfunction

   function automatic logic [11:0] m_bg(input int i);
      int l;
      if (i == 8) return 12'h222;
      l = (i >= 8) ? 8 : 4;
      return {4'((i & 4) ? l : 0), 4'((i & 2) ? l : 0), 4'((i & 1) ? l : 0)};
   endfunction

   function automatic logic [11:0] m_pix(input logic [15:0] cw, input logic [7:0] f,
                                         input int idx, input bit sw);
      bit b;
      b = f[7 - idx];
      if (sw) b = !b;
      return b ? m_fg(int'(cw[11:8])) : m_bg(int'(cw[15:12]));
   endfunction

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) frame_tick = 1;
         @(negedge clk) frame_tick = 0;
         tcount++;
         if (tcount == 32) begin tcount = 0; bvis = !bvis; end
      end
   endtask

   // drive one pixel, check two clocks later
   task automatic pix(input logic [15:0] cw, input logic [7:0] f, input int idx,
                      input int col, input int row, input string req);
      bit sw;
      logic [11:0] e;
      sw = cur_en && bvis && (col == int'(cur_col)) && (row == int'(cur_row));
      e  = m_pix(cw, f, idx, sw);
      @(negedge clk);
      pix_valid = 1; cell_word = cw; font_row = f; pix_idx = 3'(idx);
      cell_col = 7'(col); cell_row = 6'(row);
      @(negedge clk) pix_valid = 0;
      chk(rgb_valid == 0, {req, " R4 early"}, rgb_valid, 0);
      @(negedge clk);
      chk(rgb_valid == 1 && rgb == e, req, rgb, e);
   endtask

   initial begin
      rst_n = 0; frame_tick = 0; pix_valid = 0; cur_en = 0; clr_start = 0; cpu_we = 0;
      cell_word = 0; cpu_wdata = 0; font_row = 0; pix_idx = 0; cell_col = 0; cur_col = 0;
      cell_row = 0; cur_row = 0; cpu_addr = 0;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk(rgb_valid == 0 && rgb == 0, "R1 pixel out", rgb, 0);
      chk(clr_busy == 0 && mem_we == 0, "R1 write port", {clr_busy, mem_we}, 0);

      // R3 legacy index 0 and R2 MSB-first
      pix(16'h0041, 8'h80, 0, 1, 1, "R3 fg idx0 green");
      pix(16'h0041, 8'h80, 1, 1, 1, "R3 bg idx0 black");
      pix(16'h8F00, 8'h01, 7, 2, 2, "R2 lsb at last pixel");
      pix(16'h8700, 8'h00, 0, 2, 2, "R3 bg idx8");
      pix(16'h0841, 8'hFF, 3, 2, 2, "R3 fg idx8");
      pix(16'h5AFF, 8'h40, 1, 0, 0, "R2 char ignored");

      // random pixels, cursor possibly on but phase hidden: R2 R3 R6
      for (int k = 0; k < 300; k++) begin
         cur_en  = 1'($urandom);
         cur_col = 7'($urandom % 80);
         cur_row = 6'($urandom % 40);
         pix(16'($urandom), 8'($urandom), int'($urandom % 8),
             int'($urandom % 80), int'($urandom % 40), "R2 random pixel");
      end

      // blink: R5 R6
      cur_en = 1; cur_col = 7'd5; cur_row = 6'd3;
      ticks(31);
      pix(16'h1200, 8'hF0, 0, 5, 3, "R5 hidden after 31 ticks");
      ticks(1);
      chk(bvis == 1, "R5 model", bvis, 1);
      pix(16'h1200, 8'hF0, 0, 5, 3, "R6 swap at cursor");
      pix(16'h1200, 8'hF0, 6, 5, 3, "R6 swap at cursor bit0");
      pix(16'h1200, 8'hF0, 0, 6, 3, "R6 no swap other column");
      pix(16'h1200, 8'hF0, 0, 5, 4, "R6 no swap other row");
      cur_en = 0;
      pix(16'h1200, 8'hF0, 0, 5, 3, "R6 no swap cursor off");
      cur_en = 1;
      ticks(32);
      pix(16'h1200, 8'hF0, 0, 5, 3, "R5 hidden after 64 ticks");

      // idle cpu write: R8
      @(negedge clk);
      cpu_we = 1; cpu_addr = 12'h123; cpu_wdata = 16'hBEEF;
      #1;
      chk(mem_we && mem_addr == 12'h123 && mem_wdata == 16'hBEEF, "R8 idle forward",
          mem_wdata, 16'hBEEF);
      @(negedge clk) cpu_we = 0;

      // clear: R7 R8 R9
      begin
         int bad = 0, bad8 = 0;
         clr_start = 1;
         @(negedge clk) clr_start = 0;
         for (int k = 0; k < NC; k++) begin
            if (!(clr_busy && mem_we && mem_addr == 12'(k) && mem_wdata == 16'h0020)) bad++;
            if (k == 100) begin
               cpu_we = 1; cpu_addr = 12'h007; cpu_wdata = 16'hBEEF; clr_start = 1;
               #1;
               if (!(mem_addr == 12'(k) && mem_wdata == 16'h0020)) bad8++;
            end
            @(negedge clk);
            cpu_we = 0; clr_start = 0;
         end
         chk(bad == 0, "R7 clear sequence", bad, 0);
         chk(bad8 == 0, "R8 cpu write held off", bad8, 0);
         chk(clr_busy == 0 && mem_we == 0, "R9 clear ends after one pass",
             {clr_busy, mem_we}, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule